// File: doc/BRIEF.md
# RFFE Slave Command Decoder

This block is the digital front end of a small register-controlled bus slave on a two-wire RFFE bus. It oversamples the serial clock and data lines on a fast system clock, finds the sequence start condition, and decodes the command frame that follows. It accepts Extended Register Write sequences and writes their bytes into a handful of control registers. Those registers hold two DAC codes, a turbo-charge index, the enable bits, the boost voltage code and the power mode. Every register drives an output port of the block.

The only read the block answers is a plain Register Read of its status register. For that read it takes over the data line for one data frame and its parity bit, then lets go on the bus park cycle. The status register keeps a sticky record of protocol faults. These are parity failures on each frame type, sequences cut short, reads of an unmapped address and writes to an unmapped address. A complete read of the status register clears it.

Top module: `rffe_cmd_slave`

## Requirements
- R1: A sequence start is SDATA rising and then falling while SCLK stays low. It is followed by a 13-bit command frame sampled on SCLK falling edges, MSB first: slave ID[3:0], command[7:0], parity. A sequence whose slave ID differs from SLAVE_ID has no effect on any register or flag until the next sequence start.
- R2: Every frame uses odd parity, so the data bits plus the parity bit hold an odd number of ones. A command frame with bad parity sets status bit 6 and is ignored.
- R3: Command bits 7:4 equal to 0000 mark an Extended Register Write whose byte count is bits 3:0. It is followed by an 8-bit start-address frame and then (byte count + 1) data frames, each of 8 bits plus parity. These go to consecutive addresses, and one bus park cycle closes the sequence. Registers change only right after an SCLK falling edge.
- R4: Address 0x01 holds the turbo-charge index, 0x02 the DAC A code and 0x03 the DAC B code. All three reset to 0x00.
- R5: Address 0x00 is the enable mask: bit 6 drives spread-spectrum enable, bit 3 DAC A enable and bit 2 DAC B enable. After reset only spread spectrum is enabled.
- R6: Address 0x10 is the boost code. The output is {000, 1, written bits 3:0}, so bit 4 is always 1 and bits 7:5 are always 0. The reset value is 0x1B.
- R7: Address 0x1C bits 1:0 set the power mode: 00 active (reset), 01 startup, 10 low power. Writing 11 leaves the mode unchanged.
- R8: A bad address-frame parity sets status bit 4. A bad data-frame parity sets status bit 3. In both cases the failing frame and every later byte of that sequence are not written.
- R9: A data byte aimed at an unmapped address is dropped and sets status bit 1. Later bytes of the burst still go to the following addresses.
- R10: Command bits 7:5 equal to 011 are a Register Read of address bits 4:0. For STATUS_ADDR the slave lets one park cycle pass, then drives 8 status bits MSB first and an odd parity bit, launching each bit on an SCLK rising edge. It releases SDATA on the rising edge of the closing park cycle. Status layout MSB first: 0, command parity, sequence cut short, address parity, data parity, unmapped read, unmapped write, 0.
- R11: A Register Read of any other address sets status bit 2 and never drives SDATA. An Extended Register Read (command bits 7:4 = 0010) never drives SDATA.
- R12: A sequence start that arrives after a valid command frame of this slave, but before its sequence completes, sets status bit 5 and releases SDATA within one system clock.
- R13: Status flags are sticky and accumulate until a status read completes its parity bit. They are then cleared, and the next read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Bus clock, synchronous to clk |
| sdata_i | input | 1 | Resolved bus data line |
| sdata_o | output | 1 | Data bit the slave drives during a read |
| sdata_oe | output | 1 | Slave drives the data line when high |
| ss_en_o | output | 1 | Spread-spectrum enable |
| dac_a_en_o | output | 1 | DAC A enable |
| dac_b_en_o | output | 1 | DAC B enable |
| tc_index_o | output | 8 | Turbo-charge index |
| dac_a_o | output | 8 | DAC A code |
| dac_b_o | output | 8 | DAC B code |
| vhv_code_o | output | 8 | Boost voltage code |
| pwr_mode_o | output | 2 | Power mode |

## Verification
The bench builds the block with SLAVE_ID = 5 and STATUS_ADDR = 0x1A. It also sends sequences to ID 4, which exercises the path that ignores other slaves. With the status address fixed at 0x1A, both the answered read and the unmapped read of 0x05 can be tested, and every status bit can be forced one at a time and then cleared. Bursts of three bytes starting at 0x01, and two bytes starting at 0x0F, cover address increment across mapped and unmapped addresses.

// File: rtl/rffe_cmd_slave.sv
module rffe_cmd_slave #(
  parameter logic [3:0] SLAVE_ID    = 4'h5,
  parameter logic [4:0] STATUS_ADDR = 5'h1A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       sdata_i,
  output logic       sdata_o,
  output logic       sdata_oe,
  output logic       ss_en_o,
  output logic       dac_a_en_o,
  output logic       dac_b_en_o,
  output logic [7:0] tc_index_o,
  output logic [7:0] dac_a_o,
  output logic [7:0] dac_b_o,
  output logic [7:0] vhv_code_o,
  output logic [1:0] pwr_mode_o
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_PARK, ST_RD_TA, ST_RD_DATA, ST_RD_PARK
  } st_t;

  st_t         state;
  logic        sclk_q, sdata_q, armed;
  logic [12:0] sh;
  logic [3:0]  cnt, bc_left;
  logic [7:0]  waddr;
  logic [8:0]  rd_sh;
  logic [3:0]  vhv_lo;
  logic        f_cpar, f_len, f_apar, f_dpar, f_urd, f_uwr;

  logic        sclk_rise, sclk_fall, ssc;
  logic [12:0] shn;
  logic [7:0]  cmd, stat, wbyte;
  logic        in_seq;

  assign sclk_rise  = sclk_i & ~sclk_q;
  assign sclk_fall  = ~sclk_i & sclk_q;
  assign ssc        = ~sclk_i & ~sclk_q & armed & sdata_q & ~sdata_i;
  assign shn        = {sh[11:0], sdata_i};
  assign cmd        = shn[8:1];
  assign wbyte      = shn[8:1];
  assign stat       = {1'b0, f_cpar, f_len, f_apar, f_dpar, f_urd, f_uwr, 1'b0};
  assign in_seq     = (state == ST_ADDR) || (state == ST_DATA) ||
                      (state == ST_RD_TA) || (state == ST_RD_DATA);
  assign vhv_code_o = {3'b000, 1'b1, vhv_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
      armed   <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      sdata_q <= sdata_i;
      if (sclk_i || ssc)
        armed <= 1'b0;
      else if (~sclk_q & ~sdata_q & sdata_i)
        armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sh         <= '0;
      cnt        <= '0;
      bc_left    <= '0;
      waddr      <= '0;
      rd_sh      <= '0;
      sdata_o    <= 1'b0;
      sdata_oe   <= 1'b0;
      ss_en_o    <= 1'b1;
      dac_a_en_o <= 1'b0;
      dac_b_en_o <= 1'b0;
      tc_index_o <= '0;
      dac_a_o    <= '0;
      dac_b_o    <= '0;
      vhv_lo     <= 4'hB;
      pwr_mode_o <= 2'b00;
      f_cpar     <= 1'b0;
      f_len      <= 1'b0;
      f_apar     <= 1'b0;
      f_dpar     <= 1'b0;
      f_urd      <= 1'b0;
      f_uwr      <= 1'b0;
    end else if (ssc) begin
      if (in_seq) f_len <= 1'b1;
      state    <= ST_CMD;
      cnt      <= '0;
      sdata_oe <= 1'b0;
    end else if (sclk_fall) begin
      sh  <= shn;
      cnt <= cnt + 4'd1;
      case (state)
        ST_CMD: if (cnt == 4'd12) begin
          cnt <= '0;
          if (shn[12:9] != SLAVE_ID)
            state <= ST_IDLE;
          else if (!(^shn)) begin
            f_cpar <= 1'b1;
            state  <= ST_IDLE;
          end else if (cmd[7:4] == 4'b0000) begin
            bc_left <= cmd[3:0];
            state   <= ST_ADDR;
          end else if (cmd[7:5] == 3'b011) begin
            if (cmd[4:0] == STATUS_ADDR) begin
              rd_sh <= {stat, ~^stat};
              state <= ST_RD_TA;
            end else begin
              f_urd <= 1'b1;
              state <= ST_IDLE;
            end
          end else
            state <= ST_IDLE;
        end
        ST_ADDR: if (cnt == 4'd8) begin
          cnt <= '0;
          if (^shn[8:0]) begin
            waddr <= wbyte;
            state <= ST_DATA;
          end else begin
            f_apar <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_DATA: if (cnt == 4'd8) begin
          cnt <= '0;
          if (^shn[8:0]) begin
            case (waddr)
              8'h00: begin
                ss_en_o    <= wbyte[6];
                dac_a_en_o <= wbyte[3];
                dac_b_en_o <= wbyte[2];
              end
              8'h01: tc_index_o <= wbyte;
              8'h02: dac_a_o    <= wbyte;
              8'h03: dac_b_o    <= wbyte;
              8'h10: vhv_lo     <= wbyte[3:0];
              8'h1C: if (wbyte[1:0] != 2'b11) pwr_mode_o <= wbyte[1:0];
              default: f_uwr <= 1'b1;
            endcase
            waddr <= waddr + 8'd1;
            if (bc_left == 4'd0)
              state <= ST_PARK;
            else
              bc_left <= bc_left - 4'd1;
          end else begin
            f_dpar <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_PARK: state <= ST_IDLE;
        ST_RD_TA: begin
          cnt   <= '0;
          state <= ST_RD_DATA;
        end
        ST_RD_DATA: begin
          rd_sh <= {rd_sh[7:0], 1'b0};
          if (cnt == 4'd8) begin
            cnt    <= '0;
            state  <= ST_RD_PARK;
            f_cpar <= 1'b0;
            f_len  <= 1'b0;
            f_apar <= 1'b0;
            f_dpar <= 1'b0;
            f_urd  <= 1'b0;
            f_uwr  <= 1'b0;
          end
        end
        ST_RD_PARK: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end else if (sclk_rise) begin
      sdata_oe <= (state == ST_RD_DATA);
      sdata_o  <= rd_sh[8];
    end
  end

  AST_OE_RISE_ON_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(sclk_i & ~sclk_q)); // R10

  AST_OE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> ($past(sclk_i & ~sclk_q) || $past(ssc))); // R10

  AST_SSC_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ssc |=> !sdata_oe); // R12

  AST_DAC_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dac_a_o, dac_b_o, tc_index_o}) |-> $past(sclk_q & ~sclk_i)); // R3

  AST_PM_NEVER_11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode_o != 2'b11); // R7

endmodule

// File: tb/rffe_cmd_slave_tb_top.sv
module rffe_cmd_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] ID = 4'h5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic m_oe = 1'b1;
  logic m_d = 1'b0;
  logic bus;
  logic dut_o, dut_oe, ss_en, a_en, b_en;
  logic [7:0] tc, dac_a, dac_b, vhv;
  logic [1:0] pm;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus = m_oe ? m_d : (dut_oe ? dut_o : 1'b0);

  rffe_cmd_slave #(.SLAVE_ID(ID), .STATUS_ADDR(5'h1A)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(bus),
    .sdata_o(dut_o), .sdata_oe(dut_oe), .ss_en_o(ss_en),
    .dac_a_en_o(a_en), .dac_b_en_o(b_en), .tc_index_o(tc),
    .dac_a_o(dac_a), .dac_b_o(dac_b), .vhv_code_o(vhv), .pwr_mode_o(pm));

  // addr[27:20] data[19:12] sel[11:8] expected[7:0]
  // sel: 0 dac_a, 1 dac_b, 2 tc, 3 vhv, 4 pm, 5 {ss,a,b}
  localparam logic [27:0] VEC [10] = '{
    {8'h02, 8'h5A, 4'd0, 8'h5A},
    {8'h03, 8'hA5, 4'd1, 8'hA5},
    {8'h01, 8'h33, 4'd2, 8'h33},
    {8'h10, 8'hFF, 4'd3, 8'h1F},
    {8'h10, 8'h00, 4'd3, 8'h10},
    {8'h1C, 8'h01, 4'd4, 8'h01},
    {8'h1C, 8'h03, 4'd4, 8'h01},
    {8'h1C, 8'h02, 4'd4, 8'h02},
    {8'h00, 8'h08, 4'd5, 8'h02},
    {8'h00, 8'h44, 4'd5, 8'h05}
  };

  function automatic logic [7:0] obs(input logic [3:0] sel);
    case (sel)
      4'd0: return dac_a;
      4'd1: return dac_b;
      4'd2: return tc;
      4'd3: return vhv;
      4'd4: return {6'd0, pm};
      default: return {5'd0, ss_en, a_en, b_en};
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_m(input logic b);
    sclk = 1'b1; m_d = b;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [12:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_m(v[i]);
  endtask

  task automatic ssc();
    m_oe = 1'b1; m_d = 1'b0;
    repeat (2) @(negedge clk);
    m_d = 1'b1;
    repeat (2) @(negedge clk);
    m_d = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // bad: 0 none, 1 command, 2 address, 3+k data frame k
  task automatic wr_seq(input logic [3:0] sa, input logic [7:0] addr, input int n,
                        input logic [23:0] d, input int bad);
    logic [7:0] cmd, b;
    cmd = {4'b0000, 4'(n - 1)};
    ssc();
    send({sa, cmd, (~^{sa, cmd}) ^ (bad == 1)}, 13);
    send({4'd0, addr, (~^addr) ^ (bad == 2)}, 9);
    for (int k = 0; k < n; k++) begin
      b = d[23 - 8*k -: 8];
      send({4'd0, b, (~^b) ^ (bad == 3 + k)}, 9);
    end
    bit_m(1'b0);
  endtask

  task automatic rd_seq(input logic [7:0] cmd, input logic bad_par, output logic [7:0] val,
                        output logic par, output logic drove, output logic released);
    logic b;
    ssc();
    send({ID, cmd, (~^{ID, cmd}) ^ bad_par}, 13);
    bit_m(1'b0);
    m_oe = 1'b0;
    drove = 1'b0; val = '0; par = 1'b0;
    for (int i = 0; i < 9; i++) begin
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      b = bus;
      drove = drove | dut_oe;
      @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      if (i < 8) val = {val[6:0], b}; else par = b;
    end
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    released = !dut_oe;
    @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    m_oe = 1'b1; m_d = 1'b0;
  endtask

  task automatic status(input string req, input logic [7:0] exp);
    logic [7:0] v;
    logic p, dr, rl;
    rd_seq({3'b011, 5'h1A}, 1'b0, v, p, dr, rl);
    chk(req, v, exp);
    chk({req, " parity/drive/release"}, {5'd0, p, dr, rl}, {5'd0, ~^exp, 2'b11});
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic p, dr, rl;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    chk("R4 reset tc", tc, 8'h00);
    chk("R4 reset dac_a", dac_a, 8'h00);
    chk("R4 reset dac_b", dac_b, 8'h00);
    chk("R5 reset enables", obs(4'd5), 8'h04);
    chk("R6 reset vhv", vhv, 8'h1B);
    chk("R7 reset pm", {6'd0, pm}, 8'h00);
    chk("R10 reset no drive", {7'd0, dut_oe}, 8'h00);
    status("R10 R13 status after reset", 8'h00);

    for (int i = 0; i < 10; i++) begin
      wr_seq(ID, VEC[i][27:20], 1, {VEC[i][19:12], 16'h0}, 0);
      chk($sformatf("R3-map vector %0d (R4 R5 R6 R7)", i), obs(VEC[i][11:8]), VEC[i][7:0]);
    end

    wr_seq(ID, 8'h01, 3, 24'h112233, 0);
    chk("R3 burst tc", tc, 8'h11);
    chk("R3 burst dac_a", dac_a, 8'h22);
    chk("R3 burst dac_b", dac_b, 8'h33);

    wr_seq(4'h4, 8'h02, 1, 24'h770000, 0);
    chk("R1 other slave ignored", dac_a, 8'h22);
    status("R1 no flag from other slave", 8'h00);

    wr_seq(ID, 8'h02, 1, 24'h770000, 1);
    chk("R2 cmd parity blocks write", dac_a, 8'h22);
    status("R2 cmd parity flag", 8'h40);
    status("R13 flags cleared", 8'h00);

    wr_seq(ID, 8'h02, 1, 24'h770000, 2);
    chk("R8 addr parity blocks write", dac_a, 8'h22);
    status("R8 addr parity flag", 8'h10);

    wr_seq(ID, 8'h01, 3, 24'h445566, 4);
    chk("R8 byte before bad frame written", tc, 8'h44);
    chk("R8 bad frame not written", dac_a, 8'h22);
    chk("R8 byte after bad frame not written", dac_b, 8'h33);
    status("R8 data parity flag", 8'h08);

    wr_seq(ID, 8'h0F, 2, 24'h123400, 0);
    chk("R9 burst continues past unmapped", vhv, 8'h14);
    status("R9 unmapped write flag", 8'h02);

    rd_seq({3'b011, 5'h05}, 1'b0, v, p, dr, rl);
    chk("R11 unmapped read no drive", {7'd0, dr}, 8'h00);
    status("R11 unmapped read flag", 8'h04);

    rd_seq(8'h20, 1'b0, v, p, dr, rl);
    chk("R11 extended read no drive", {7'd0, dr}, 8'h00);
    status("R11 extended read no flag", 8'h00);

    ssc();
    send({ID, 3'b011, 5'h1A, ~^{ID, 3'b011, 5'h1A}}, 13);
    bit_m(1'b0);
    m_oe = 1'b0;
    for (int i = 0; i < 3; i++) bit_m(1'b0);
    chk("R12 driving before abort", {7'd0, dut_oe}, 8'h01);
    ssc();
    chk("R12 abort releases", {7'd0, dut_oe}, 8'h00);
    status("R12 short sequence flag", 8'h20);

    rd_seq({3'b011, 5'h1A}, 1'b1, v, p, dr, rl);
    rd_seq({3'b011, 5'h03}, 1'b0, v, p, dr, rl);
    status("R13 flags accumulate", 8'h44);
    status("R13 cleared after read", 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule